// File: doc/BRIEF.md
# Dual-Mode Oversampling Sample Buffer

This block gathers conversion results from a set of analog channels into a per-channel row of five sample slots. Once a frame is complete, it copies the whole array into an output image in a single clock cycle. Each publish is marked by a one-cycle strobe and counted by a wrapping cycle counter. The converter that produces the results and the transport that carries the image are both outside the block.

Two timing sources are available. In free-running mode, an internal tick paces the sampling, nominally once per millisecond. The image is published after N ticks, where N is the oversampling factor (1 to 5). In sync mode, each pulse on a sample input takes one measurement and each pulse on a publish input closes the frame. In both modes, the sample taken k-th within a frame lands in slot k of every channel. Slots at index N or above are published as zero. Mode and factor changes wait for the next frame start.

Top module: `osamp_image_buf`

## Requirements
- R1: After a synchronous reset, `image_o`, `cycle_cnt_o`, `pub_o` and `overrun_o` are all zero.
- R2: The factor input is used as given for values 1 to 5. A value of 0 acts as 1, and values 6 or 7 act as 5.
- R3: In free-running mode (`mode_i` = 0), publishes occur exactly every N×`TICK_CYC` clock cycles. The sync inputs have no effect in this mode.
- R4: In sync mode (`mode_i` = 1), the k-th sample pulse of a frame (k counted from 0) fills slot k of each channel. Slot s of channel c sits at `image_o[(c*5+s)*SW +: SW]`.
- R5: Slots whose index is N or higher are published as zero, even if a sample was taken for them.
- R6: A publish pulse that closes a frame holding fewer than N samples publishes the filled slots and zero in every unfilled slot.
- R7: In sync mode, sample pulses beyond the fifth in a frame are discarded and set `overrun_o`. That flag stays high until reset.
- R8: Every slot of every channel changes in the same cycle, and `pub_o` is high for exactly that one cycle. Its rising edge comes one clock after the edge that samples a publish pulse. At all other times, `image_o` holds its value.
- R9: `cycle_cnt_o` increases by one at each publish, wraps from its maximum to zero, and is otherwise unchanged.
- R10: The mode and factor are frozen from the first sample of a frame until that frame is published. A change made mid-frame applies to the next frame.
- R11: A sample copies each channel's most recent result marked by its valid strobe. A channel with no new valid strobe repeats its previous result.
- R12: In sync mode, the internal tick neither takes a sample nor publishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = free-running tick, 1 = external sync pulses |
| factor_i | input | 3 | Oversampling factor request |
| smp_data_i | input | NCH*SW | Conversion results, channel c at bits c*SW |
| smp_valid_i | input | NCH | Per-channel result valid strobe |
| sync_smp_i | input | 1 | Sync mode: take one sample |
| sync_pub_i | input | 1 | Sync mode: publish the frame |
| image_o | output | NCH*5*SW | Published sample image |
| pub_o | output | 1 | One-cycle publish strobe |
| cycle_cnt_o | output | CW | Publish counter |
| overrun_o | output | 1 | Sticky surplus-sample flag |

## Verification
- **Holding register:** a valid strobe sampled at one edge is ready for a sample pulse sampled at the following edge.
- **Sample slot:** a sample pulse writes its slot at the edge that samples it.
- **Publish:** a publish pulse sampled at edge E updates `image_o`, raises `pub_o` and advances `cycle_cnt_o` at edge E+1. The strobe falls again at E+2.
- **Bench timing:** inputs are driven and outputs read on falling edges. The bench therefore raises the publish pulse, lowers it one falling edge later, and checks the image, strobe and counter at the falling edge after that. It then confirms one falling edge later that the strobe has dropped and the image is unchanged.
- **Free-running mode:** the bench measures the number of falling edges between consecutive strobes and compares it with N×`TICK_CYC`.

// File: rtl/osb_pkg.sv
`timescale 1ns/1ps
package osb_pkg;

    localparam int MAX_SLOTS = 5;
    localparam int IDX_W     = 3;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } osb_mode_e;

    typedef struct packed {
        osb_mode_e             mode;
        logic [IDX_W-1:0]      n;
    } osb_cfg_t;

    // Bring a requested factor into the legal 1..MAX_SLOTS range.
    function automatic logic [IDX_W-1:0] clamp_factor(input logic [IDX_W-1:0] f);
        if (f == '0)
            return IDX_W'(1);
        else if (f > IDX_W'(MAX_SLOTS))
            return IDX_W'(MAX_SLOTS);
        return f;
    endfunction

    // A slot belongs to the published frame only below the factor.
    function automatic logic slot_kept(input logic [IDX_W-1:0] s, input logic [IDX_W-1:0] n);
        return s < n;
    endfunction

endpackage

// File: rtl/osb_tick_gen.sv
`timescale 1ns/1ps
module osb_tick_gen #(
    parameter int PERIOD = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/osb_hold_bank.sv
`timescale 1ns/1ps
module osb_hold_bank #(
    parameter int NCH = 4,
    parameter int SW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH*SW-1:0] data_i,
    input  logic [NCH-1:0]    valid_i,
    output logic [NCH*SW-1:0] hold_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SW-1:0] hold_q;
        always_ff @(posedge clk) begin
            if (rst)
                hold_q <= '0;
            else if (valid_i[c])
                hold_q <= data_i[c*SW +: SW];
        end
        assign hold_o[c*SW +: SW] = hold_q;
    end
endmodule

// File: rtl/osb_frame_ctrl.sv
`timescale 1ns/1ps
module osb_frame_ctrl
    import osb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic [IDX_W-1:0] factor_i,
    input  logic             tick_i,
    input  logic             smp_i,
    input  logic             pub_i,
    output logic             cap_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o,
    output logic [IDX_W-1:0] fin_n_o,
    output logic             overrun_o
);
    osb_cfg_t         act_q, req, eff;
    logic [IDX_W-1:0] cnt_q, fin_n_q, base;
    logic             done_q, ovr_q;
    logic             open_w, trig, cap, ovr_evt, end_evt;

    always_comb begin
        req.mode = osb_mode_e'(mode_i);
        req.n    = clamp_factor(factor_i);
        // A frame with no sample yet (or one being closed) takes new settings.
        open_w   = (cnt_q == '0) || done_q;
        eff      = open_w ? req : act_q;
        base     = done_q ? '0 : cnt_q;
        trig     = (eff.mode == MODE_FREE) ? tick_i : smp_i;
        cap      = trig && (base < IDX_W'(MAX_SLOTS));
        ovr_evt  = trig && !cap;
        if (eff.mode == MODE_FREE)
            end_evt = tick_i && (base == (eff.n - IDX_W'(1)));
        else
            end_evt = pub_i && !done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '{mode: MODE_FREE, n: IDX_W'(MAX_SLOTS)};
            cnt_q   <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            fin_n_q <= IDX_W'(MAX_SLOTS);
        end else begin
            if (open_w)
                act_q <= req;
            cnt_q  <= base + IDX_W'(cap);
            done_q <= end_evt;
            if (end_evt)
                fin_n_q <= eff.n;
            if (ovr_evt)
                ovr_q <= 1'b1;
        end
    end

    assign cap_o     = cap;
    assign idx_o     = base;
    assign done_o    = done_q;
    assign fin_n_o   = fin_n_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/osb_sample_store.sv
`timescale 1ns/1ps
module osb_sample_store
    import osb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    parameter int CW  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH*SW-1:0]           hold_i,
    input  logic                        cap_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic                        done_i,
    input  logic [IDX_W-1:0]            fin_n_i,
    output logic [NCH*MAX_SLOTS*SW-1:0] image_o,
    output logic                        pub_o,
    output logic [CW-1:0]               count_o
);
    typedef logic [MAX_SLOTS-1:0][SW-1:0] lane_t;

    lane_t                                  slot_w [NCH];
    logic [NCH-1:0][MAX_SLOTS-1:0][SW-1:0]  masked, img_q;
    logic                                   pub_q;
    logic [CW-1:0]                          cnt_q;

    // One working lane per channel; cleared on publish, written on capture.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        lane_t lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else begin
                for (int s = 0; s < MAX_SLOTS; s++) begin
                    if (done_i)
                        lane_q[s] <= '0;
                    if (cap_i && (idx_i == IDX_W'(s)))
                        lane_q[s] <= hold_i[c*SW +: SW];
                end
            end
        end
        assign slot_w[c] = lane_q;
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < MAX_SLOTS; s++)
                masked[c][s] = slot_kept(IDX_W'(s), fin_n_i) ? slot_w[c][s] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
            pub_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pub_q <= done_i;
            if (done_i) begin
                img_q <= masked;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign image_o = img_q;
    assign pub_o   = pub_q;
    assign count_o = cnt_q;
endmodule

// File: rtl/osamp_image_buf.sv
`timescale 1ns/1ps
module osamp_image_buf
    import osb_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int SW       = 16,
    parameter int CW       = 16,
    parameter int TICK_CYC = 125000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_i,
    input  logic [IDX_W-1:0]            factor_i,
    input  logic [NCH*SW-1:0]           smp_data_i,
    input  logic [NCH-1:0]              smp_valid_i,
    input  logic                        sync_smp_i,
    input  logic                        sync_pub_i,
    output logic [NCH*MAX_SLOTS*SW-1:0] image_o,
    output logic                        pub_o,
    output logic [CW-1:0]               cycle_cnt_o,
    output logic                        overrun_o
);
    logic              tick_w, cap_w, done_w;
    logic [IDX_W-1:0]  idx_w, fin_n_w;
    logic [NCH*SW-1:0] hold_w;

    osb_tick_gen #(.PERIOD(TICK_CYC)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    osb_hold_bank #(.NCH(NCH), .SW(SW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .data_i  (smp_data_i),
        .valid_i (smp_valid_i),
        .hold_o  (hold_w)
    );

    osb_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .factor_i  (factor_i),
        .tick_i    (tick_w),
        .smp_i     (sync_smp_i),
        .pub_i     (sync_pub_i),
        .cap_o     (cap_w),
        .idx_o     (idx_w),
        .done_o    (done_w),
        .fin_n_o   (fin_n_w),
        .overrun_o (overrun_o)
    );

    osb_sample_store #(.NCH(NCH), .SW(SW), .CW(CW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .hold_i  (hold_w),
        .cap_i   (cap_w),
        .idx_i   (idx_w),
        .done_i  (done_w),
        .fin_n_i (fin_n_w),
        .image_o (image_o),
        .pub_o   (pub_o),
        .count_o (cycle_cnt_o)
    );
endmodule

// File: rtl/osb_image_chk.sv
`timescale 1ns/1ps
module osb_image_chk
    import osb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    parameter int CW  = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        pub,
    input logic [CW-1:0]               cnt,
    input logic [NCH*MAX_SLOTS*SW-1:0] image,
    input logic                        ovr,
    input logic [IDX_W-1:0]            frame_n,
    input logic                        done
);
    logic [IDX_W-1:0] prev_n;
    logic             blank_ok;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= IDX_W'(MAX_SLOTS);
        else     prev_n <= frame_n;
    end

    always_comb begin
        blank_ok = 1'b1;
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < MAX_SLOTS; s++)
                if ((IDX_W'(s) >= prev_n) && (image[(c*MAX_SLOTS+s)*SW +: SW] != '0))
                    blank_ok = 1'b0;
    end

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (rst)
        pub |-> (cnt == $past(cnt) + CW'(1)));

    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pub |-> $stable(cnt));

    assert_image_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !pub |-> $stable(image));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        pub |=> !pub);

    assert_close_to_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> pub);

    assert_blank_slots_R5: assert property (@(posedge clk) disable iff (rst)
        pub |-> blank_ok);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);
endmodule

bind osamp_image_buf osb_image_chk #(.NCH(NCH), .SW(SW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pub     (pub_o),
    .cnt     (cycle_cnt_o),
    .image   (image_o),
    .ovr     (overrun_o),
    .frame_n (fin_n_w),
    .done    (done_w)
);

// File: tb/osamp_image_buf_tb.sv
`timescale 1ns/1ps
module osamp_image_buf_tb;
    localparam int NCH   = 4;
    localparam int SW    = 16;
    localparam int NS    = 5;
    localparam int CW    = 16;
    localparam int TICK  = 10;
    localparam int IMG_W = NCH*NS*SW;

    logic              clk = 1'b0;
    logic              rst;
    logic              mode_i;
    logic [2:0]        factor_i;
    logic [NCH*SW-1:0] smp_data_i;
    logic [NCH-1:0]    smp_valid_i;
    logic              sync_smp_i, sync_pub_i;
    logic [IMG_W-1:0]  image_o;
    logic              pub_o;
    logic [CW-1:0]     cycle_cnt_o;
    logic              overrun_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [SW-1:0] hold_m [NCH];
    logic [SW-1:0] fr_m   [NCH][NS];
    int            k_m;

    always #4 clk = ~clk;

    osamp_image_buf #(.NCH(NCH), .SW(SW), .CW(CW), .TICK_CYC(TICK)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .factor_i    (factor_i),
        .smp_data_i  (smp_data_i),
        .smp_valid_i (smp_valid_i),
        .sync_smp_i  (sync_smp_i),
        .sync_pub_i  (sync_pub_i),
        .image_o     (image_o),
        .pub_o       (pub_o),
        .cycle_cnt_o (cycle_cnt_o),
        .overrun_o   (overrun_o)
    );

    task automatic check(input string tag, input logic [IMG_W-1:0] act, input logic [IMG_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_frame();
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < NS; s++)
                fr_m[c][s] = '0;
        k_m = 0;
    endtask

    function automatic logic [IMG_W-1:0] expected_image(input int n);
        logic [IMG_W-1:0] e = '0;
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < NS; s++)
                if (s < n) e[(c*NS+s)*SW +: SW] = fr_m[c][s];
        return e;
    endfunction

    // Load new results on the masked channels, then fire one sample pulse.
    task automatic do_sample(input logic [NCH-1:0] vmask, input logic [SW-1:0] base);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            smp_data_i[c*SW +: SW] = base + SW'(c*256);
            if (vmask[c]) hold_m[c] = base + SW'(c*256);
        end
        smp_valid_i = vmask;
        @(negedge clk);
        smp_valid_i = '0;
        sync_smp_i  = 1'b1;
        if (k_m < NS)
            for (int c = 0; c < NCH; c++) fr_m[c][k_m] = hold_m[c];
        k_m++;
        @(negedge clk);
        sync_smp_i = 1'b0;
    endtask

    // Publish pulse; strobe, counter and image are due one edge after it is sampled.
    task automatic publish_check(input int n, input string tag);
        logic [CW-1:0]    c0 = cycle_cnt_o;
        logic [IMG_W-1:0] snap;
        @(negedge clk);
        sync_pub_i = 1'b1;
        @(negedge clk);
        sync_pub_i = 1'b0;
        @(negedge clk);
        check({tag, " R8 strobe high"}, IMG_W'(pub_o), IMG_W'(1));
        check({tag, " R9 counter step"}, IMG_W'(cycle_cnt_o), IMG_W'(c0 + CW'(1)));
        check({tag, " image"}, image_o, expected_image(n));
        snap = image_o;
        @(negedge clk);
        check({tag, " R8 strobe one cycle"}, IMG_W'(pub_o), IMG_W'(0));
        check({tag, " R8 image held"}, image_o, snap);
        clear_frame();
    endtask

    task automatic wait_pub(input bit noisy, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (noisy) begin
                sync_pub_i = (cyc % 7 == 3);
                sync_smp_i = (cyc % 5 == 1);
            end
        end while (!pub_o && cyc < 2000);
        sync_pub_i = 1'b0;
        sync_smp_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 image", image_o, '0);
        check("R1 pub", IMG_W'(pub_o), '0);
        check("R1 counter", IMG_W'(cycle_cnt_o), '0);
        check("R1 overrun", IMG_W'(overrun_o), '0);
    endtask

    task automatic t_sync_full();
        mode_i = 1'b1; factor_i = 3'd5;
        for (int k = 0; k < 5; k++) do_sample('1, SW'(16'h0010 + k));
        publish_check(5, "R4 five samples");
    endtask

    task automatic t_tick_ignored();
        int seen = 0;
        for (int i = 0; i < 4*TICK; i++) begin
            @(negedge clk);
            if (pub_o) seen++;
        end
        check("R12 no publish from tick", IMG_W'(seen), '0);
        do_sample('1, 16'h0A00);
        publish_check(5, "R12 slot0 after ticks");
    endtask

    task automatic t_blank_slots();
        factor_i = 3'd4;
        for (int k = 0; k < 5; k++) do_sample('1, SW'(16'h0020 + k));
        publish_check(4, "R5 slot4 blank");
    endtask

    task automatic t_short_frame();
        factor_i = 3'd5;
        do_sample('1, 16'h0030);
        do_sample('1, 16'h0031);
        publish_check(5, "R6 short frame");
    endtask

    task automatic t_clamp();
        factor_i = 3'd0;
        do_sample('1, 16'h0040);
        do_sample('1, 16'h0041);
        publish_check(1, "R2 factor 0");
        factor_i = 3'd7;
        for (int k = 0; k < 5; k++) do_sample('1, SW'(16'h0050 + k));
        publish_check(5, "R2 factor 7");
    endtask

    task automatic t_partial_valid();
        factor_i = 3'd3;
        do_sample(4'b1111, 16'h0100);
        do_sample(4'b0001, 16'h0200);
        do_sample(4'b0100, 16'h0300);
        publish_check(3, "R11 per-channel hold");
    endtask

    task automatic t_overrun();
        factor_i = 3'd5;
        check("R7 overrun clear", IMG_W'(overrun_o), '0);
        for (int k = 0; k < 7; k++) do_sample('1, SW'(16'h0060 + k));
        check("R7 overrun set", IMG_W'(overrun_o), IMG_W'(1));
        publish_check(5, "R7 first five kept");
        do_sample('1, 16'h0070);
        publish_check(5, "R7 next frame");
        check("R7 overrun sticky", IMG_W'(overrun_o), IMG_W'(1));
    endtask

    task automatic t_cfg_freeze();
        factor_i = 3'd5;
        do_sample('1, 16'h0080);
        do_sample('1, 16'h0081);
        factor_i = 3'd2;
        for (int k = 0; k < 3; k++) do_sample('1, SW'(16'h0082 + k));
        publish_check(5, "R10 frozen factor");
        for (int k = 0; k < 3; k++) do_sample('1, SW'(16'h0090 + k));
        publish_check(2, "R10 new factor");
    endtask

    task automatic t_free();
        int cyc;
        logic [CW-1:0] c0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            smp_data_i[c*SW +: SW] = SW'(16'h7000 + c);
            hold_m[c] = SW'(16'h7000 + c);
        end
        smp_valid_i = '1;
        mode_i = 1'b0; factor_i = 3'd3;
        @(negedge clk);
        smp_valid_i = '0;
        wait_pub(1'b0, cyc);
        c0 = cycle_cnt_o;
        wait_pub(1'b1, cyc);
        check("R3 period N=3", IMG_W'(cyc), IMG_W'(3*TICK));
        check("R9 free counter step", IMG_W'(cycle_cnt_o), IMG_W'(c0 + CW'(1)));
        clear_frame();
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 3; s++) fr_m[c][s] = hold_m[c];
        check("R3 free image", image_o, expected_image(3));
        factor_i = 3'd1;
        wait_pub(1'b0, cyc);
        wait_pub(1'b1, cyc);
        check("R3 period N=1", IMG_W'(cyc), IMG_W'(TICK));
    endtask

    initial begin : main
        rst = 1'b1; mode_i = 1'b1; factor_i = 3'd5;
        smp_data_i = '0; smp_valid_i = '0; sync_smp_i = 1'b0; sync_pub_i = 1'b0;
        for (int c = 0; c < NCH; c++) hold_m[c] = '0;
        clear_frame();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sync_full();
        t_tick_ignored();
        t_blank_slots();
        t_short_frame();
        t_clamp();
        t_partial_valid();
        t_overrun();
        t_cfg_freeze();
        t_free();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule